// File: doc/BRIEF.md
# Weighted Priority Command Scheduler

This block picks at most one command per scheduler update from three sources. An immediate command is offered directly on its own port and is never stored. High and low priority commands are each written into a private FIFO. Every stored entry carries a command word, a length field and a Fletcher-16 checksum, and the entry is validated only when it reaches the head of its queue and is chosen.

Over time the high queue is served twice as often as the low queue, using a repeating high, high, low pattern. A bad checksum drops that one entry. A length that cannot be valid empties the whole queue it came from. Either case uses up the update without a dispatch. The dispatch output is a one-cycle strobe with the source and the command word. It cannot be stalled, because each update makes at most one decision.

Queue inputs use valid/ready. A push completes on a clock edge where both are high. Ready falls when the queue holds DEPTH entries, and also in a cycle where that queue is being flushed. A source must keep its valid and data steady until ready is seen. The immediate port is also valid/ready: it is accepted only on an update, and it must be held until then.

Top module: `cmd_sched`

## Requirements
- R1: After reset no dispatch is presented (out_valid 0, out_src 0), both queues are empty and both queue ready outputs are 1. A reset during operation discards all queued entries.
- R2: out_valid rises only in the cycle after an update. An update with no immediate command and both queues empty produces no dispatch. A command pushed into a queue is never dispatched without an update.
- R3: On an update where imm_valid is 1, the immediate command is dispatched and accepted (imm_ready equals update), whatever the queues hold. This does not advance the high/low pattern.
- R4: When both queues hold valid entries, successive queue services follow the repeating pattern high, high, low. The pattern starts at the first high after reset.
- R5: If the queue the pattern selects is empty, the other queue is served on that update, and the pattern still advances.
- R6: An update that serves nothing leaves the pattern position unchanged.
- R7: The checksum is {s2,s1}. s1 and s2 start at 0. For each byte in the order command low byte, command high byte, then the length zero-extended to a byte: s1 = (s1+byte) mod 255, then s2 = (s2+s1) mod 255. A selected entry whose stored checksum differs is dropped without a dispatch. This uses up that update, and the pattern advances.
- R8: A length is valid only from 1 to CMD_W/8 inclusive (1 or 2 by default). A selected entry with any other length empties its whole queue without a dispatch, and the pattern advances. The other queue is untouched.
- R9: Each queue returns entries in push order. Its ready output is 0 while it holds DEPTH entries, and a push offered then is not stored.
- R10: out_src is 1 for immediate, 2 for high and 3 for low while out_valid is 1, and 0 otherwise. out_cmd carries the dispatched command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_valid | input | 1 | High queue push offered |
| hi_ready | output | 1 | High queue can accept |
| hi_cmd | input | CMD_W | High entry command word |
| hi_len | input | LEN_W | High entry length field |
| hi_sum | input | 16 | High entry Fletcher-16 checksum |
| lo_valid | input | 1 | Low queue push offered |
| lo_ready | output | 1 | Low queue can accept |
| lo_cmd | input | CMD_W | Low entry command word |
| lo_len | input | LEN_W | Low entry length field |
| lo_sum | input | 16 | Low entry Fletcher-16 checksum |
| imm_valid | input | 1 | Immediate command pending |
| imm_ready | output | 1 | Immediate command taken this cycle |
| imm_cmd | input | CMD_W | Immediate command word |
| update | input | 1 | Scheduler update strobe |
| out_valid | output | 1 | Dispatch strobe, one cycle |
| out_src | output | 2 | Dispatch source code |
| out_cmd | output | CMD_W | Dispatched command word |

## Verification
The main stimulus fills both queues and then issues updates. This shows that the high, high, low order is real weighting and not a simple alternation. The same updates are then repeated with one queue drained, which exposes the fallback, and with idle updates placed between services, which shows whether an idle update advances the pattern. An immediate command offered while both queues are loaded separates true precedence from a merely ordered arbiter. A corrupted checksum followed by a good entry shows that exactly one entry is dropped, while a zero length and an over-long length show that the whole queue is emptied. Filling a queue to depth and resetting mid-run cover back-pressure and clearing.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IMM  = 2'd1,
    SRC_HI   = 2'd2,
    SRC_LO   = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    PH_HI_A = 2'd0,
    PH_HI_B = 2'd1,
    PH_LO   = 2'd2
  } phase_e;

  // running-sum step modulo 255, inputs below 255 and 256
  function automatic logic [7:0] add_mod255(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    if (t >= 9'd255) t = t - 9'd255;
    return t[7:0];
  endfunction

endpackage

// File: rtl/cs_fifo.sv
module cs_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign in_ready = (cnt != CW'(DEPTH)) && !flush;
  assign push     = in_valid && in_ready;
  assign empty    = (cnt == '0);
  assign pop_ok   = pop && !empty;
  assign head     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= step(wp);
      if (pop_ok) rp <= step(rp);
      case ({push, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/cs_entry_check.sv
module cs_entry_check
  import cmd_sched_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int LEN_W = 4
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic [LEN_W-1:0] len,
  input  logic [15:0]      sum,
  output logic             len_ok,
  output logic             sum_ok
);
  localparam int NB = CMD_W / 8;

  logic [7:0] s1, s2;

  always_comb begin
    s1 = '0;
    s2 = '0;
    for (int i = 0; i < NB; i++) begin
      s1 = add_mod255(s1, cmd[8*i +: 8]);
      s2 = add_mod255(s2, s1);
    end
    s1 = add_mod255(s1, 8'(len));
    s2 = add_mod255(s2, s1);
  end

  assign sum_ok = (sum == {s2, s1});
  assign len_ok = (len != '0) && (32'(len) <= NB);
endmodule

// File: rtl/cs_pick.sv
module cs_pick
  import cmd_sched_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       update,
  input  logic       imm_valid,
  input  logic [1:0] q_empty,
  input  logic [1:0] q_len_ok,
  input  logic [1:0] q_sum_ok,
  output logic       take_imm,
  output logic [1:0] q_pop,
  output logic [1:0] q_flush,
  output logic       disp_v,
  output src_e       disp_src
);
  phase_e ph;
  logic   pref_hi, sel_hi, sel_lo, serve;

  assign pref_hi  = (ph != PH_LO);
  assign sel_hi   = !q_empty[0] && (pref_hi || q_empty[1]);
  assign sel_lo   = !q_empty[1] && !sel_hi;
  assign take_imm = update && imm_valid;
  assign serve    = update && !imm_valid && (sel_hi || sel_lo);

  assign q_pop[0]   = serve && sel_hi &&  q_len_ok[0];
  assign q_pop[1]   = serve && sel_lo &&  q_len_ok[1];
  assign q_flush[0] = serve && sel_hi && !q_len_ok[0];
  assign q_flush[1] = serve && sel_lo && !q_len_ok[1];

  assign disp_v = take_imm || (q_pop[0] && q_sum_ok[0]) || (q_pop[1] && q_sum_ok[1]);

  always_comb begin
    if (take_imm)      disp_src = SRC_IMM;
    else if (q_pop[0]) disp_src = SRC_HI;
    else if (q_pop[1]) disp_src = SRC_LO;
    else               disp_src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_HI_A;
    end else if (serve) begin
      case (ph)
        PH_HI_A: ph <= PH_HI_B;
        PH_HI_B: ph <= PH_LO;
        default: ph <= PH_HI_A;
      endcase
    end
  end
endmodule

// File: rtl/cmd_sched.sv
module cmd_sched
  import cmd_sched_pkg::*;
#(
  parameter int CMD_W = 16,
  parameter int LEN_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hi_valid,
  output logic             hi_ready,
  input  logic [CMD_W-1:0] hi_cmd,
  input  logic [LEN_W-1:0] hi_len,
  input  logic [15:0]      hi_sum,
  input  logic             lo_valid,
  output logic             lo_ready,
  input  logic [CMD_W-1:0] lo_cmd,
  input  logic [LEN_W-1:0] lo_len,
  input  logic [15:0]      lo_sum,
  input  logic             imm_valid,
  output logic             imm_ready,
  input  logic [CMD_W-1:0] imm_cmd,
  input  logic             update,
  output logic             out_valid,
  output logic [1:0]       out_src,
  output logic [CMD_W-1:0] out_cmd
);
  localparam int QW = CMD_W + LEN_W + 16;
  localparam int NQ = 2;

  logic [QW-1:0]    q_in_d   [NQ];
  logic [QW-1:0]    q_head   [NQ];
  logic [CMD_W-1:0] q_cmd    [NQ];
  logic [NQ-1:0]    q_in_v, q_rdy, q_empty, q_len_ok, q_sum_ok, q_pop, q_flush;
  logic             take_imm, disp_v;
  src_e             disp_src;
  logic [CMD_W-1:0] disp_cmd;

  assign q_in_v    = {lo_valid, hi_valid};
  assign q_in_d[0] = {hi_cmd, hi_len, hi_sum};
  assign q_in_d[1] = {lo_cmd, lo_len, lo_sum};
  assign hi_ready  = q_rdy[0];
  assign lo_ready  = q_rdy[1];
  assign imm_ready = update;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    cs_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (q_in_v[g]),
      .in_ready (q_rdy[g]),
      .in_data  (q_in_d[g]),
      .pop      (q_pop[g]),
      .flush    (q_flush[g]),
      .head     (q_head[g]),
      .empty    (q_empty[g])
    );

    assign q_cmd[g] = q_head[g][QW-1 -: CMD_W];

    cs_entry_check #(.CMD_W(CMD_W), .LEN_W(LEN_W)) u_chk (
      .cmd    (q_cmd[g]),
      .len    (q_head[g][16 +: LEN_W]),
      .sum    (q_head[g][15:0]),
      .len_ok (q_len_ok[g]),
      .sum_ok (q_sum_ok[g])
    );
  end

  cs_pick u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .update    (update),
    .imm_valid (imm_valid),
    .q_empty   (q_empty),
    .q_len_ok  (q_len_ok),
    .q_sum_ok  (q_sum_ok),
    .take_imm  (take_imm),
    .q_pop     (q_pop),
    .q_flush   (q_flush),
    .disp_v    (disp_v),
    .disp_src  (disp_src)
  );

  assign disp_cmd = take_imm ? imm_cmd : (q_pop[0] ? q_cmd[0] : q_cmd[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_src   <= SRC_NONE;
      out_cmd   <= '0;
    end else begin
      out_valid <= disp_v;
      out_src   <= disp_v ? disp_src : SRC_NONE;
      out_cmd   <= disp_v ? disp_cmd : '0;
    end
  end
endmodule

// File: rtl/cmd_sched_chk.sv
module cmd_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       update,
  input logic       imm_valid,
  input logic       out_valid,
  input logic [1:0] out_src,
  input logic [1:0] q_empty,
  input logic [1:0] q_flush
);
  p_out_after_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(update));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !imm_valid && (q_empty == 2'b11)) |=> !out_valid);

  p_imm_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (update && imm_valid) |=> (out_valid && out_src == 2'd1));

  p_flush_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush[0] |=> q_empty[0]);

  p_flush_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_flush[1] |=> q_empty[1]);

  p_src_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (out_src != 2'd0));
endmodule

bind cmd_sched cmd_sched_chk u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .update    (update),
  .imm_valid (imm_valid),
  .out_valid (out_valid),
  .out_src   (out_src),
  .q_empty   (q_empty),
  .q_flush   (q_flush)
);

// File: tb/cmd_sched_test.sv
module cmd_sched_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        hi_valid, lo_valid, imm_valid, update;
  logic        hi_ready, lo_ready, imm_ready, out_valid;
  logic [15:0] hi_cmd, lo_cmd, imm_cmd, hi_sum, lo_sum, out_cmd;
  logic [3:0]  hi_len, lo_len;
  logic [1:0]  out_src;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cmd_sched uut (
    .clk(clk), .rst_n(rst_n),
    .hi_valid(hi_valid), .hi_ready(hi_ready), .hi_cmd(hi_cmd), .hi_len(hi_len), .hi_sum(hi_sum),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_cmd(lo_cmd), .lo_len(lo_len), .lo_sum(lo_sum),
    .imm_valid(imm_valid), .imm_ready(imm_ready), .imm_cmd(imm_cmd),
    .update(update), .out_valid(out_valid), .out_src(out_src), .out_cmd(out_cmd)
  );

  // ops: 0 push high, 1 push low, 2 offer immediate, 3 update and check
  // row = {op[1:0], cmd[15:0], len[3:0], bad, exp_valid, exp_src[1:0]}
  localparam int NROW = 34;
  localparam logic [25:0] TBL [0:NROW-1] = '{
    {2'd0, 16'hA001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd0, 16'hA002, 4'd1, 1'b0, 1'b0, 2'd0},
    {2'd0, 16'hA003, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'hB001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'hB002, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'hB003, 4'd1, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'hA001, 4'd0, 1'b0, 1'b1, 2'd2}, // R4 high
    {2'd3, 16'hA002, 4'd0, 1'b0, 1'b1, 2'd2}, // R4 high
    {2'd3, 16'hB001, 4'd0, 1'b0, 1'b1, 2'd3}, // R4 low
    {2'd3, 16'hA003, 4'd0, 1'b0, 1'b1, 2'd2}, // R4 high
    {2'd3, 16'hB002, 4'd0, 1'b0, 1'b1, 2'd3}, // R5 fallback to low
    {2'd3, 16'hB003, 4'd0, 1'b0, 1'b1, 2'd3},
    {2'd3, 16'h0000, 4'd0, 1'b0, 1'b0, 2'd0}, // R2 idle
    {2'd0, 16'hC001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'hD001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd2, 16'hE001, 4'd0, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'hE001, 4'd0, 1'b0, 1'b1, 2'd1}, // R3 immediate first
    {2'd3, 16'hC001, 4'd0, 1'b0, 1'b1, 2'd2},
    {2'd3, 16'hD001, 4'd0, 1'b0, 1'b1, 2'd3}, // R5
    {2'd3, 16'h0000, 4'd0, 1'b0, 1'b0, 2'd0}, // R6 idle, pattern held at low
    {2'd0, 16'hF001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'h6001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'h6001, 4'd0, 1'b0, 1'b1, 2'd3}, // R6 low still due
    {2'd3, 16'hF001, 4'd0, 1'b0, 1'b1, 2'd2},
    {2'd0, 16'h7001, 4'd2, 1'b1, 1'b0, 2'd0},
    {2'd0, 16'h7002, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'h0000, 4'd0, 1'b0, 1'b0, 2'd0}, // R7 dropped
    {2'd3, 16'h7002, 4'd0, 1'b0, 1'b1, 2'd2}, // R7 next entry
    {2'd1, 16'h8001, 4'd0, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'h8002, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd1, 16'h8003, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'h0000, 4'd0, 1'b0, 1'b0, 2'd0}, // R8 zero length flush
    {2'd0, 16'h9001, 4'd2, 1'b0, 1'b0, 2'd0},
    {2'd3, 16'h9001, 4'd0, 1'b0, 1'b1, 2'd2}
  };

  function automatic logic [15:0] fl16(input logic [15:0] c, input logic [3:0] l);
    int s1 = 0, s2 = 0;
    int b [3];
    b[0] = int'(c[7:0]);
    b[1] = int'(c[15:8]);
    b[2] = int'(l);
    for (int i = 0; i < 3; i++) begin
      s1 = (s1 + b[i]) % 255;
      s2 = (s2 + s1) % 255;
    end
    return {8'(s2), 8'(s1)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic push(input int q, input logic [15:0] c, input logic [3:0] l, input bit bad);
    @(negedge clk);
    if (q == 0) begin
      hi_valid = 1; hi_cmd = c; hi_len = l; hi_sum = fl16(c, l) ^ {15'd0, bad};
    end else begin
      lo_valid = 1; lo_cmd = c; lo_len = l; lo_sum = fl16(c, l) ^ {15'd0, bad};
    end
    @(posedge clk);
    #1;
    hi_valid = 0;
    lo_valid = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 no dispatch without update", 32'(out_valid), 0);
  endtask

  task automatic tick(input bit ev, input logic [1:0] es, input logic [15:0] ec, input string req);
    @(negedge clk);
    update = 1;
    @(posedge clk);
    #1;
    update    = 0;
    imm_valid = 0;
    @(negedge clk);
    check(out_valid == ev, req, 32'(out_valid), 32'(ev));
    check(out_src == es, {req, " R10 source"}, 32'(out_src), 32'(es));
    if (ev) check(out_cmd == ec, {req, " R10 command"}, 32'(out_cmd), 32'(ec));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 0; update = 0; imm_valid = 0; imm_cmd = 0;
    hi_valid = 0; hi_cmd = 0; hi_len = 0; hi_sum = 0;
    lo_valid = 0; lo_cmd = 0; lo_len = 0; lo_sum = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0 && out_src == 0, "R1 reset output", {30'd0, out_src}, 0);
    rst_n = 1;
    @(negedge clk);
    check(hi_ready && lo_ready, "R1 ready after reset", {30'd0, hi_ready, lo_ready}, 3);

    // table walk: R3 R4 R5 R6 R7 R8 R10
    for (int r = 0; r < NROW; r++) begin
      logic [1:0] op;
      op = TBL[r][25:24];
      case (op)
        2'd0: push(0, TBL[r][23:8], TBL[r][7:4], TBL[r][3]);
        2'd1: push(1, TBL[r][23:8], TBL[r][7:4], TBL[r][3]);
        2'd2: begin @(negedge clk); imm_valid = 1; imm_cmd = TBL[r][23:8]; end
        default: tick(TBL[r][2], TBL[r][1:0], TBL[r][23:8], $sformatf("table row %0d", r));
      endcase
    end
    tick(0, 0, 0, "R8 low queue emptied by flush");

    // R8 over-long length (3 > 2 bytes) flushes the high queue
    push(0, 16'h5A01, 4'd3, 0);
    push(0, 16'h5A02, 4'd2, 0);
    tick(0, 0, 0, "R8 over-long length");
    tick(0, 0, 0, "R8 whole high queue cleared");
    check(hi_ready == 1, "R8 ready after flush", 32'(hi_ready), 1);

    // R9 fill to depth, order and back-pressure
    for (int i = 0; i < 4; i++) push(0, 16'h3000 + 16'(i), 4'd2, 0);
    @(negedge clk);
    check(hi_ready == 0, "R9 ready low when full", 32'(hi_ready), 0);
    hi_valid = 1; hi_cmd = 16'h3FFF; hi_len = 4'd2; hi_sum = fl16(16'h3FFF, 4'd2);
    @(posedge clk);
    #1;
    hi_valid = 0;
    for (int i = 0; i < 4; i++) tick(1, 2'd2, 16'h3000 + 16'(i), "R9 push order");
    tick(0, 0, 0, "R9 refused push not stored");

    // R3 immediate alone on an otherwise empty block
    @(negedge clk);
    imm_valid = 1; imm_cmd = 16'h4242;
    check(imm_ready == 0, "R3 not taken without update", 32'(imm_ready), 0);
    tick(1, 2'd1, 16'h4242, "R3 immediate dispatch");

    // R1 reset mid-run clears queued entries
    push(0, 16'h1111, 4'd2, 0);
    push(1, 16'h2222, 4'd2, 0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    tick(0, 0, 0, "R1 queues cleared by reset");

    finish_run();
  end
endmodule